// File: doc/BRIEF.md
# Phase-Offset Integer Clock Divider

This block divides a timing clock by a programmable integer ratio. Its output can be shifted by a programmed number of half-periods of the divider's input clock. The timing clock runs at twice the input-clock rate, so one half input period is one timing-clock cycle. The output therefore toggles once every `D` timing cycles, where `D` is the active divide value.

The phase shift is not a continuous delay. It is applied once, as a start delay before the first output period that follows a synchronization release. Every later period uses only the divide value.

Divide and phase settings on the configuration inputs take effect only at a release strobe or at reset. While the divider runs, changes to them are held pending.

- A level input blanks the output while synchronization is in progress.
- A per-output flag makes the divider ignore both the blanking level and the release strobe, so that output keeps running undisturbed.

Top module: `hpdiv_top`

## Requirements
- R1: Reset acts as a release. While `rst` is high the output is low and both settings are loaded. The first rising output edge comes `1+P` cycles after the last clock edge with `rst` high, where `P` is the loaded phase.
- R2: While running, the output toggles every `D` timing cycles, giving an output period of `2*D` cycles.
- R3: A divide setting of 1 makes the output toggle on every timing cycle. A divide setting of 0 behaves exactly as 1.
- R4: On a clock edge where `sync_release` is 1 and `ignore_sync` is 0, the block loads `div_cfg` and `phase_cfg` as the active settings and drives the output low.
- R5: After a release on edge `t`, the output stays low until edge `t+1+P`, where it rises. `P` ranges from 0 to 63, and each step is one timing cycle (half an input period).
- R6: The phase delay applies only to the first period after a release. All later toggles are spaced `D` cycles apart.
- R7: Changes to `div_cfg` or `phase_cfg` while the divider runs do not alter the output until the next release or reset.
- R8: While `sync_active` is 1 and `ignore_sync` is 0 with no release, the output is driven low and the divider stops. It stays stopped until a release.
- R9: While `ignore_sync` is 1, `sync_active` and `sync_release` have no effect. The output keeps its pattern and the active settings are not reloaded.
- R10: When `sync_release` and `sync_active` are both 1 on the same edge, the release wins.
- R11: With divide 2, the first rising edge after a release with phase 6 comes exactly 6 cycles later than with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the divider's input-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W (8) | Pending divide value |
| phase_cfg | input | PH_W (6) | Pending phase offset in half input periods |
| ignore_sync | input | 1 | When 1, sync level and release are ignored |
| sync_active | input | 1 | Synchronization in progress; output blanked |
| sync_release | input | 1 | One-cycle strobe that ends synchronization and loads the settings |
| clk_out | output | 1 | Divided, phase-shifted clock |

## Verification
The bench builds the block with its default widths: an 8-bit divide value and a 6-bit phase. This brings the full phase range up to 63, and both degenerate divide values 0 and 1, into reach within a short run.

A behavioural model tracks the cycle number of the next expected toggle. It is compared with the output on every cycle through:
- reset start-up;
- pending changes while running;
- blanking, with a release arriving during blanking;
- the ignore flag;
- the maximum phase.

Directed measurements of release-to-first-rise latency confirm the 6-cycle shift at divide 2.

// File: rtl/hpdiv_pkg.sv
package hpdiv_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } hp_state_t;
endpackage

// File: rtl/hpdiv_shadow.sv
module hpdiv_shadow #(
  parameter int DIV_W = 8,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [PH_W-1:0]  ph_in,
  output logic [DIV_W-1:0] div_o,
  output logic [PH_W-1:0]  ph_o
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  // Active settings: loaded only on reset or an accepted release.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      div_o <= (div_in == '0) ? DIV_ONE : div_in;
      ph_o  <= ph_in;
    end
  end

  AST_NO_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
    div_o != '0); // R3
  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_o) && $stable(ph_o)); // R7
endmodule

// File: rtl/hpdiv_seq.sv
module hpdiv_seq
  import hpdiv_pkg::*;
#(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rel_eff,
  input  logic            sync_eff,
  input  logic [PH_W-1:0] ph_in,
  output logic            start_o,
  output logic            clear_o,
  output hp_state_t       state_o
);
  logic [PH_W-1:0] wait_cnt;

  assign start_o = !rel_eff && !sync_eff && (state_o == ST_DELAY) && (wait_cnt == '0);
  assign clear_o = rel_eff || sync_eff || ((state_o != ST_RUN) && !start_o);

  always_ff @(posedge clk) begin
    if (rst || rel_eff) begin
      state_o  <= ST_DELAY;
      wait_cnt <= ph_in;
    end else if (sync_eff) begin
      state_o  <= ST_HOLD;
    end else if (state_o == ST_DELAY) begin
      if (wait_cnt == '0) state_o <= ST_RUN;
      else                wait_cnt <= wait_cnt - 1'b1;
    end
  end

  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_HOLD) && !rel_eff |=> state_o == ST_HOLD); // R8
  AST_DELAY_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DELAY) && (wait_cnt != '0) && !rel_eff && !sync_eff
      |=> state_o == ST_DELAY); // R5
endmodule

// File: rtl/hpdiv_toggle.sv
module hpdiv_toggle #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             out
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      out <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      out <= 1'b1;
      cnt <= div - 1'b1;
    end else if (cnt == '0) begin
      out <= ~out;
      cnt <= div - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !clear && !start && (cnt != '0) |=> $stable(out)); // R2
endmodule

// File: rtl/hpdiv_top.sv
module hpdiv_top
  import hpdiv_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [PH_W-1:0]  phase_cfg,
  input  logic             ignore_sync,
  input  logic             sync_active,
  input  logic             sync_release,
  output logic             clk_out
);
  logic             rel_eff, sync_eff, start_w, clear_w;
  logic [DIV_W-1:0] div_act;
  logic [PH_W-1:0]  ph_act;
  hp_state_t        state_w;

  assign rel_eff  = sync_release && !ignore_sync;
  assign sync_eff = sync_active  && !ignore_sync;

  hpdiv_shadow #(.DIV_W(DIV_W), .PH_W(PH_W)) shadow_i (
    .clk(clk), .rst(rst), .load(rel_eff),
    .div_in(div_cfg), .ph_in(phase_cfg),
    .div_o(div_act), .ph_o(ph_act)
  );

  hpdiv_seq #(.PH_W(PH_W)) seq_i (
    .clk(clk), .rst(rst), .rel_eff(rel_eff), .sync_eff(sync_eff),
    .ph_in(phase_cfg), .start_o(start_w), .clear_o(clear_w), .state_o(state_w)
  );

  hpdiv_toggle #(.DIV_W(DIV_W)) toggle_i (
    .clk(clk), .rst(rst), .clear(clear_w), .start(start_w),
    .div(div_act), .out(clk_out)
  );

  AST_SYNC_LOW: assert property (@(posedge clk) disable iff (rst)
    sync_active && !ignore_sync && !sync_release |=> !clk_out); // R8
  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (rst)
    sync_release && !ignore_sync |=> !clk_out && (state_w == ST_DELAY)); // R10
  AST_START_RISE: assert property (@(posedge clk) disable iff (rst)
    start_w |=> clk_out); // R5
  AST_IGNORE_RUN: assert property (@(posedge clk) disable iff (rst)
    ignore_sync && (state_w == ST_RUN) |=> state_w == ST_RUN); // R9
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (rst)
    ignore_sync |=> $stable(ph_act)); // R9
endmodule

// File: tb/hpdiv_top_tb_top.sv
`timescale 1ns/1ps
module hpdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_cfg = 8'd3;
  logic [5:0] phase_cfg = 6'd2;
  logic       ignore_sync = 1'b0;
  logic       sync_active = 1'b0;
  logic       sync_release = 1'b0;
  logic       clk_out;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural model state
  longint cyc = 0;
  longint next_tog = -1;
  int     m_div = 1;
  bit     m_out = 1'b0;

  always #2 clk = ~clk;

  hpdiv_top dut_i (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .phase_cfg(phase_cfg),
    .ignore_sync(ignore_sync), .sync_active(sync_active),
    .sync_release(sync_release), .clk_out(clk_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst || (sync_release && !ignore_sync)) begin
      m_div    = (div_cfg == 0) ? 1 : int'(div_cfg);
      m_out    = 1'b0;
      next_tog = cyc + 1 + phase_cfg;
    end else if (sync_active && !ignore_sync) begin
      m_out    = 1'b0;
      next_tog = -1;
    end else if (next_tog >= 0 && cyc == next_tog) begin
      m_out    = ~m_out;
      next_tog = cyc + m_div;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (clk_out !== m_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: clk_out=%0b expected %0b", cur_req, cyc, clk_out, m_out);
      end
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_now(input int d, input int p);
    div_cfg = 8'(d); phase_cfg = 6'(p);
    sync_release = 1'b1;
    @(negedge clk);
    sync_release = 1'b0;
  endtask

  // measures negedges from release drive to first high output
  task automatic latency(input int p, output int k);
    div_cfg = 8'd2; phase_cfg = 6'(p);
    sync_release = 1'b1;
    k = 0;
    @(negedge clk); k++;
    sync_release = 1'b0;
    while (clk_out !== 1'b1 && k < 200) begin
      @(negedge clk); k++;
    end
  endtask

  initial begin
    int k0, k6;
    cur_req = "R1";
    run(3);
    n_vec++;
    if (clk_out !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset: clk_out=%0b expected 0", clk_out);
    end
    rst = 1'b0;
    run(30);
    cur_req = "R2";
    run(20);
    cur_req = "R7";
    div_cfg = 8'd5; phase_cfg = 6'd9;
    run(25);
    cur_req = "R4";
    release_now(5, 9);
    cur_req = "R5";
    run(15);
    cur_req = "R6";
    run(40);
    cur_req = "R8";
    sync_active = 1'b1;
    run(10);
    cur_req = "R10";
    div_cfg = 8'd4; phase_cfg = 6'd3;
    sync_release = 1'b1;
    run(1);
    sync_release = 1'b0; sync_active = 1'b0;
    run(30);
    cur_req = "R3";
    release_now(1, 0);
    run(12);
    release_now(0, 4);
    run(12);
    cur_req = "R9";
    release_now(3, 1);
    run(10);
    ignore_sync = 1'b1;
    div_cfg = 8'd7; phase_cfg = 6'd20;
    sync_active = 1'b1;
    run(6);
    sync_release = 1'b1;
    run(1);
    sync_release = 1'b0; sync_active = 1'b0;
    run(20);
    ignore_sync = 1'b0;
    run(5);
    cur_req = "R5";
    release_now(2, 63);
    run(90);
    cur_req = "R11";
    run(4);
    latency(0, k0);
    run(10);
    latency(6, k6);
    run(10);
    n_vec++;
    if (k0 != 2) begin
      n_bad++; $display("FAIL R11 phase0 latency: got %0d expected 2", k0);
    end
    n_vec++;
    if (k6 - k0 != 6) begin
      n_bad++; $display("FAIL R11 phase shift: got %0d expected 6", k6 - k0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog %s: run hung, expected completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule